// File: doc/BRIEF.md
# GPIO Pad Bank with Interrupt Detection

This block is a memory-mapped controller for a bank of general-purpose pads (44 by default). Each pad has its own configuration word and value word on a simple word-wide register bus. Through these words software sets the pad direction, the output level and push-pull or open-drain drive. It also picks how the pad raises an interrupt. Pull-strength, pull-direction, function-select and a direct-interrupt flag are kept only as stored fields. Each pad also has two general storage words.

Each pad input passes through a two-flop synchronizer. A per-pad trigger unit then watches for rising edges, falling edges, either edge, a high level or a low level. When its condition is met it sets a sticky status bit. The status bits are packed 32 to a word in a separate region and are cleared by writing ones. A single interrupt line is high whenever any status bit is set.

Top module: `gpb_pad_bank`

## Requirements
- R1: Byte address map: pad p's configuration word is at p*16, its value word at p*16+8, and its storage words at p*16+4 and p*16+12. Status word k is at 0x800+4*k, and its bit j belongs to pad 32*k+j. Read data follows the address in the same cycle.
- R2: Configuration bits 31, 27, 26:24, 10:7 and 2:0 can be written and read back. All other configuration bits read as 0. Both storage words hold all 32 bits.
- R3: After reset every configuration word, storage word and status bit is 0. Value bits 2:1 read 11, pad_oe is low on every pad and irq_out is low.
- R4: When value bit 1 is 0, the pad is driven (pad_oe high) with pad_out equal to the written value bit 0. When value bit 1 is 1, pad_oe is low.
- R5: When configuration bit 31 is set, the pad is driven low only while the written level is 0 and value bit 1 is 0. A written level of 1 releases the pad (pad_oe low). pad_out is then 0.
- R6: Value bit 0 reads the pad input after a two-flop synchronizer, so it reflects a pad change after two clock edges.
- R7: With configuration bit 24 clear, bits 26:25 select the edge trigger: 01 is rising, 10 is falling, 11 is both edges, and 00 is off. A qualifying input change sets the pad's status bit on the third clock edge after the change.
- R8: With configuration bit 24 set, bit 25 selects active-high and bit 26 selects active-low level triggering. The status bit is set again on every cycle while the level is active, so a clear during that time has no lasting effect.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it was. A set event and a clear on the same bit in the same cycle leave the bit set.
- R10: When value bit 2 is 1 (input disabled), the pad raises no trigger event of any kind.
- R11: irq_out is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NUM_PADS | Pad input levels |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad driver enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
Faults in a pad's trigger state show up at the ports in one of two ways: as a status bit that fails to set, or as a spurious status bit and irq_out, within three clock edges of the pad change that should have caused them. A corrupted status register shows up immediately on the next status read. It also shows on irq_out, either as a bit that will not clear or as a bit that a write of 0 clears. Faults in direction or drive state appear on pad_oe and pad_out one edge after the value write.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int PAD_IDX_W  = 7;
    localparam logic [DATA_W-1:0] CFG_KEEP_MASK = 32'h8F00_0787;

    localparam int CFG_OPEN_DRAIN = 31;
    localparam int CFG_TRIG_LOW   = 26;
    localparam int CFG_TRIG_HIGH  = 25;
    localparam int CFG_TRIG_LEVEL = 24;

    typedef enum logic [1:0] {
        WORD_CFG  = 2'd0,
        WORD_AUXA = 2'd1,
        WORD_VAL  = 2'd2,
        WORD_AUXB = 2'd3
    } pad_word_e;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] aux_a;
        logic [DATA_W-1:0] aux_b;
        logic              in_dis;
        logic              drv_dis;
        logic              lvl;
        logic              sync1;
        logic              sync2;
        logic              prev;
    } pad_state_t;
endpackage

// File: rtl/gpb_pad_slice.sv
module gpb_pad_slice
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              val_we,
    input  logic              auxa_we,
    input  logic              auxb_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pad_in,
    output logic [DATA_W-1:0] cfg_o,
    output logic [DATA_W-1:0] val_o,
    output logic [DATA_W-1:0] auxa_o,
    output logic [DATA_W-1:0] auxb_o,
    output logic              event_o,
    output logic              pad_out,
    output logic              pad_oe
);
    pad_state_t st_d, st_q;
    logic rise, fall, edge_hit, level_hit;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pad_in;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        if (cfg_we)  st_d.cfg   = wdata & CFG_KEEP_MASK;
        if (auxa_we) st_d.aux_a = wdata;
        if (auxb_we) st_d.aux_b = wdata;
        if (val_we) begin
            st_d.in_dis  = wdata[2];
            st_d.drv_dis = wdata[1];
            st_d.lvl     = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.in_dis  <= 1'b1;
            st_q.drv_dis <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rise      = st_q.sync2 & ~st_q.prev;
        fall      = ~st_q.sync2 & st_q.prev;
        edge_hit  = (st_q.cfg[CFG_TRIG_HIGH] & rise) | (st_q.cfg[CFG_TRIG_LOW] & fall);
        level_hit = (st_q.cfg[CFG_TRIG_HIGH] & st_q.sync2) |
                    (st_q.cfg[CFG_TRIG_LOW] & ~st_q.sync2);
        event_o   = ~st_q.in_dis & (st_q.cfg[CFG_TRIG_LEVEL] ? level_hit : edge_hit);
        pad_out   = st_q.cfg[CFG_OPEN_DRAIN] ? 1'b0 : st_q.lvl;
        pad_oe    = ~st_q.drv_dis & ~(st_q.cfg[CFG_OPEN_DRAIN] & st_q.lvl);
        cfg_o     = st_q.cfg;
        auxa_o    = st_q.aux_a;
        auxb_o    = st_q.aux_b;
        val_o     = {{(DATA_W-3){1'b0}}, st_q.in_dis, st_q.drv_dis, st_q.sync2};
    end

    // R4: a driven pad always has its active-low driver enable at 0
    assert_oe_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (val_o[1] == 1'b0));

    // R5: an open-drain pad never drives a high level
    assert_od_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && cfg_o[CFG_OPEN_DRAIN]) |-> (pad_out == 1'b0));

    // R7: an edge event needs the synchronized input to have moved
    assert_edge_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !cfg_o[CFG_TRIG_LEVEL]) |-> (val_o[0] != $past(val_o[0])));
endmodule

// File: rtl/gpb_irq_status.sv
module gpb_irq_status
    import gpb_pkg::*;
#(
    parameter int NUM_PADS = 44,
    localparam int NUM_WORDS = (NUM_PADS + DATA_W - 1) / DATA_W,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PADS-1:0]       evt,
    input  logic                      clr_we,
    input  logic [WIDX_W-1:0]         clr_word,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_WORDS*DATA_W-1:0] words_o,
    output logic                      irq_out
);
    typedef struct packed {
        logic [NUM_PADS-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;
    logic [NUM_PADS-1:0] clr_vec;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (clr_we && clr_word == WIDX_W'(p / DATA_W))
                clr_vec[p] = wdata[p % DATA_W];
        end
        st_d.bits = (st_q.bits & ~clr_vec) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        words_o = '0;
        words_o[NUM_PADS-1:0] = st_q.bits;
        irq_out = |st_q.bits;
    end

    // R9: a cleared bit with no simultaneous event reads 0 afterwards
    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.bits & $past(clr_vec & ~evt)) == '0));

    // R9: an event always lands, even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.bits & $past(evt)) == $past(evt)));

    // R9: bits neither cleared nor set hold their value
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.bits ^ $past(st_q.bits)) & ~$past(clr_vec | evt)) == '0));

    // R11: the interrupt line only rises after an event
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(evt) != '0));
endmodule

// File: rtl/gpb_pad_bank.sv
module gpb_pad_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PADS = 44
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                irq_out
);
    localparam int NUM_WORDS = (NUM_PADS + DATA_W - 1) / DATA_W;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic                  in_status;
    logic [PAD_IDX_W-1:0]  pad_sel;
    pad_word_e             word_sel;
    logic [WIDX_W-1:0]     stat_sel;
    logic [NUM_PADS-1:0]   evt;
    logic [DATA_W-1:0]     cfg_arr  [NUM_PADS];
    logic [DATA_W-1:0]     val_arr  [NUM_PADS];
    logic [DATA_W-1:0]     auxa_arr [NUM_PADS];
    logic [DATA_W-1:0]     auxb_arr [NUM_PADS];
    logic [NUM_WORDS*DATA_W-1:0] stat_words;
    logic                  unused_addr;

    assign in_status   = bus_addr[11];
    assign pad_sel     = bus_addr[10:4];
    assign word_sel    = pad_word_e'(bus_addr[3:2]);
    assign stat_sel    = bus_addr[WIDX_W+1:2];
    assign unused_addr = ^{bus_addr[1:0], bus_addr[10:WIDX_W+2]};

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        logic hit;
        assign hit = bus_wr_en && !in_status && (pad_sel == PAD_IDX_W'(p));
        gpb_pad_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (hit && word_sel == WORD_CFG),
            .val_we  (hit && word_sel == WORD_VAL),
            .auxa_we (hit && word_sel == WORD_AUXA),
            .auxb_we (hit && word_sel == WORD_AUXB),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[p]),
            .cfg_o   (cfg_arr[p]),
            .val_o   (val_arr[p]),
            .auxa_o  (auxa_arr[p]),
            .auxb_o  (auxb_arr[p]),
            .event_o (evt[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p])
        );
    end

    gpb_irq_status #(.NUM_PADS(NUM_PADS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (bus_wr_en && in_status),
        .clr_word (stat_sel),
        .wdata    (bus_wdata),
        .words_o  (stat_words),
        .irq_out  (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_status) begin
            for (int k = 0; k < NUM_WORDS; k++)
                if (stat_sel == WIDX_W'(k)) bus_rdata = stat_words[k*DATA_W +: DATA_W];
        end else begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (pad_sel == PAD_IDX_W'(p)) begin
                    case (word_sel)
                        WORD_CFG:  bus_rdata = cfg_arr[p];
                        WORD_VAL:  bus_rdata = val_arr[p];
                        WORD_AUXA: bus_rdata = auxa_arr[p];
                        default:   bus_rdata = auxb_arr[p];
                    endcase
                end
            end
        end
    end

    // R3: out of reset no pad is driven and no interrupt is pending
    assert_reset_quiet_R3: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && !irq_out));
endmodule

// File: tb/gpb_pad_bank_tb_top.sv
module gpb_pad_bank_tb_top;
    localparam int N = 44;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic         irq_out;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpb_pad_bank #(.NUM_PADS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    function automatic logic [11:0] cfg_a(int p); return 12'(p * 16); endfunction
    function automatic logic [11:0] val_a(int p); return 12'(p * 16 + 8); endfunction
    function automatic logic [11:0] st_a(int p);  return 12'(12'h800 + 4 * (p / 32)); endfunction

    // expected status after a pad moves from a0 to a1; mode: 0 off,1 rise,2 fall,3 both,4 high,5 low
    function automatic logic exp_trig(int mode, logic a0, logic a1, logic in_dis);
        if (in_dis) return 1'b0;
        case (mode)
            1: return !a0 && a1;
            2: return a0 && !a1;
            3: return a0 != a1;
            4: return a1;
            5: return !a1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mode_cfg(int mode);
        case (mode)
            1: return 32'h0200_0000;
            2: return 32'h0400_0000;
            3: return 32'h0600_0000;
            4: return 32'h0300_0000;
            5: return 32'h0500_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R3 reset state
        rd(cfg_a(5), r);  chk("R3 cfg", r, 32'h0);
        rd(val_a(5), r);  chk("R3 val", r, 32'h6);
        rd(cfg_a(5) + 12'h4, r); chk("R3 aux", r, 32'h0);
        rd(st_a(0), r);   chk("R3 status", r, 32'h0);
        chk("R3 oe", 32'(pad_oe != '0), 32'h0);
        chk("R3 irq", 32'(irq_out), 32'h0);

        // R1 R2 storage and address map
        for (int i = 0; i < 12; i++) begin
            int p = int'($urandom % N);
            logic [31:0] c = $urandom, x = $urandom, y = $urandom;
            wr(cfg_a(p), c);
            wr(cfg_a(p) + 12'h4, x);
            wr(cfg_a(p) + 12'hC, y);
            rd(cfg_a(p), r); chk("R2 cfg fields", r, c & 32'h8F00_0787);
            rd(cfg_a(p) + 12'h4, r); chk("R1 aux word a", r, x);
            rd(cfg_a(p) + 12'hC, r); chk("R1 aux word b", r, y);
            wr(cfg_a(p), 32'h0);
        end

        // R4 push-pull drive
        wr(val_a(3), 32'h5);
        chk("R4 drive high oe", 32'(pad_oe[3]), 32'h1);
        chk("R4 drive high out", 32'(pad_out[3]), 32'h1);
        wr(val_a(3), 32'h4);
        chk("R4 drive low out", 32'(pad_out[3]), 32'h0);
        wr(val_a(3), 32'h7);
        chk("R4 disabled oe", 32'(pad_oe[3]), 32'h0);

        // R5 open drain
        wr(cfg_a(3), 32'h8000_0000);
        wr(val_a(3), 32'h5);
        chk("R5 od release", 32'(pad_oe[3]), 32'h0);
        wr(val_a(3), 32'h4);
        chk("R5 od pull low oe", 32'(pad_oe[3]), 32'h1);
        chk("R5 od pull low out", 32'(pad_out[3]), 32'h0);
        wr(val_a(3), 32'h6);
        wr(cfg_a(3), 32'h0);

        // R6 synchronized readback
        pad_in[9] = 1'b1;
        @(negedge clk);
        rd(val_a(9), r); chk("R6 one edge", r & 32'h1, 32'h0);
        @(negedge clk);
        rd(val_a(9), r); chk("R6 two edges", r & 32'h1, 32'h1);
        pad_in[9] = 1'b0;
        idle(3);

        // R7 R8 R10 random triggers on random pads
        for (int i = 0; i < 60; i++) begin
            int p = int'($urandom % N);
            int mode = int'($urandom % 6);
            logic a0 = 1'($urandom), a1 = 1'($urandom);
            logic dis = (($urandom % 5) == 0);
            logic e;
            pad_in[p] = a0;
            idle(4);
            wr(val_a(p), {29'h0, dis, 2'b10});
            wr(cfg_a(p), mode_cfg(mode));
            idle(2);
            wr(st_a(p), 32'hFFFF_FFFF);
            pad_in[p] = a1;
            idle(4);
            if (mode >= 4) wr(st_a(p), 32'hFFFF_FFFF);
            idle(2);
            e = exp_trig(mode, a0, a1, dis);
            rd(st_a(p), r);
            chk(dis ? "R10 status" : (mode >= 4 ? "R8 status" : "R7 status"),
                32'(r[p % 32]), 32'(e));
            chk("R11 irq", 32'(irq_out), 32'(e));
            wr(cfg_a(p), 32'h0);
            wr(st_a(p), 32'hFFFF_FFFF);
        end

        // R8 level persists over clear; R9 set wins
        pad_in[40] = 1'b1;
        wr(val_a(40), 32'h2);
        wr(cfg_a(40), 32'h0300_0000);
        idle(4);
        wr(st_a(40), 32'h0000_0100);
        rd(st_a(40), r); chk("R8 level reasserts (R9 set wins)", 32'(r[8]), 32'h1);
        wr(cfg_a(40), 32'h0);
        wr(st_a(40), 32'h0000_0100);
        rd(st_a(40), r); chk("R9 clear", 32'(r[8]), 32'h0);

        // R9 write of zero keeps, write of one clears
        pad_in[7] = 1'b0;
        wr(val_a(7), 32'h2);
        wr(cfg_a(7), 32'h0200_0000);
        idle(3);
        pad_in[7] = 1'b1;
        idle(4);
        wr(st_a(7), 32'h0);
        rd(st_a(7), r); chk("R9 zero write keeps", 32'(r[7]), 32'h1);
        chk("R11 irq set", 32'(irq_out), 32'h1);
        wr(st_a(7), 32'h80);
        rd(st_a(7), r); chk("R9 one write clears", 32'(r[7]), 32'h0);
        chk("R11 irq clear", 32'(irq_out), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule